// File: doc/BRIEF.md
# Generalized Bit-Reverse Permutation Unit

This block performs the generalized-reverse permutation used by bit-manipulation instructions. A chain of conditional swap stages processes a data operand. Stage k is enabled by bit k of a control operand. When stage k is enabled, it exchanges every pair of neighbouring 2^k-bit groups. The stages run from the smallest group (single bits) to the largest (half the word).

The net effect is simple to state. Result bit i is taken from operand bit (i XOR c), where c is the control value truncated to the implemented stages. A register-form control ignores its upper bits. An immediate-form control that is out of range is reported as illegal, and the result is forced to zero.

A word flag applies to the 64-bit configuration. It permutes only the low 32 bits with the five small stages and sign-extends the outcome. Control values that amount to a whole-byte reversal raise a byte-swap indication, so that downstream logic can treat them as a special case.

Operands enter on a valid/ready stream, and results leave on one. With the default output register, a result appears one cycle after acceptance. The result is held while the consumer stalls. A new operand is accepted whenever the output slot is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`).

Top module: `grev_unit`

## Requirements
- R1: Full mode, with `in_word`=0 and a legal control: `out_data[i] = in_data[i ^ (in_ctrl mod XLEN)]`. Control bits at or above log2(XLEN) have no effect in register form (`in_imm`=0).
- R2: Word mode, with `in_word`=1 on XLEN=64: `out_data[i] = in_data[i ^ (in_ctrl mod 32)]` for i<32, and bits 63..32 copy bit 31. Operand bits 63..32 and control bits 5 and above have no effect in register form.
- R3: When `in_imm`=1 and `in_ctrl` is at least 64 (full mode) or at least 32 (word mode), `out_illegal`=1 and `out_data`=0. Otherwise `out_illegal`=0.
- R4: `out_bswap`=1 exactly when the result is legal and the effective control equals XLEN-8 (0x38) in full mode, or 0x18 in word mode. In that case `out_data` is the byte-reversed operand.
- R5: An effective control of zero returns the operand unchanged.
- R6: Applying the same control twice returns the original operand. In word mode, the result is the sign-extended low word.
- R7: `out_valid` rises in the cycle after a transfer is accepted. While `out_valid`=1 and `out_ready`=0, the values of `out_data`, `out_illegal` and `out_bswap` do not change. `in_ready` = `!out_valid || out_ready`.
- R8: While `rst_n`=0, `out_valid` is 0, and no input is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Unit can accept an operand pair |
| in_data | input | XLEN | Operand to permute |
| in_ctrl | input | XLEN | Swap control value (register or immediate) |
| in_imm | input | 1 | Control comes from an immediate (range-checked) |
| in_word | input | 1 | 32-bit word mode (only meaningful when XLEN=64) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | XLEN | Permuted result |
| out_illegal | output | 1 | Immediate out of range, result zeroed |
| out_bswap | output | 1 | Control is the byte-reversal special case |

## Verification
The checker assumes that the flag and operand inputs are stable during any cycle in which `in_valid` is high. The assumption matters because the word-mode sign-extension and zero-control pass-through properties are evaluated on the combinational result ahead of the register.

The handshake-stall property assumes that the consumer may hold `out_ready` low for any number of cycles. The bench drives inputs only at falling edges and keeps each operand constant until acceptance. It also varies the stall length at random, from zero to several cycles.

Immediates are drawn from a range that straddles both the 32 and 64 limits, so that legal and illegal encodings both occur.

// File: rtl/grev_pkg.sv
package grev_pkg;
  // Mask selecting the lower group of each adjacent pair of 2^k-bit groups.
  function automatic logic [63:0] grp_mask(input int k);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = (((i >> k) & 1) == 0);
    return m;
  endfunction
endpackage

// File: rtl/grev_stage.sv
module grev_stage #(
  parameter int W = 64,
  parameter int K = 0
) (
  input  logic [W-1:0] x_i,
  input  logic         en_i,
  output logic [W-1:0] y_o
);
  localparam int          SH = 1 << K;
  localparam logic [63:0] MF = grev_pkg::grp_mask(K);
  localparam logic [W-1:0] M = MF[W-1:0];

  always_comb begin
    if (en_i) y_o = ((x_i & M) << SH) | ((x_i >> SH) & M);
    else      y_o = x_i;
  end
endmodule

// File: rtl/grev_net.sv
module grev_net #(
  parameter int W = 64,
  localparam int NST = $clog2(W)
) (
  input  logic [W-1:0]   d_i,
  input  logic [NST-1:0] c_i,
  output logic [W-1:0]   r_o
);
  logic [W-1:0] chain [NST+1];
  assign chain[0] = d_i;

  for (genvar k = 0; k < NST; k++) begin : g_stg
    grev_stage #(.W(W), .K(k)) u_stage (
      .x_i (chain[k]),
      .en_i(c_i[k]),
      .y_o (chain[k+1])
    );
  end

  assign r_o = chain[NST];
endmodule

// File: rtl/grev_ctrl_chk.sv
module grev_ctrl_chk #(
  parameter int XLEN = 64,
  localparam int NST = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] ctrl_i,
  input  logic            imm_i,
  input  logic            word_i,
  output logic            illegal_o,
  output logic            bswap_o
);
  localparam logic [XLEN-1:0] LIM_FULL = XLEN;
  localparam logic [XLEN-1:0] LIM_WORD = 32;
  localparam logic [NST-1:0]  REV8_FULL = NST'(XLEN - 8);
  localparam logic [NST-1:0]  REV8_WORD = NST'(24);

  logic           wmode;
  logic [NST-1:0] eff;

  assign wmode = (XLEN == 64) && word_i;

  always_comb begin
    eff = ctrl_i[NST-1:0];
    if (wmode) eff[NST-1] = 1'b0;
  end

  assign illegal_o = imm_i && (ctrl_i >= (wmode ? LIM_WORD : LIM_FULL));
  assign bswap_o   = !illegal_o && (eff == (wmode ? REV8_WORD : REV8_FULL));
endmodule

// File: rtl/grev_pipe.sv
module grev_pipe #(
  parameter int PW  = 66,
  parameter bit REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [PW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [PW-1:0] m_data
);
  if (REG) begin : g_reg
    logic          v_q;
    logic [PW-1:0] d_q;
    assign s_ready = !v_q || m_ready;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        if (s_ready) v_q <= s_valid;
        if (s_valid && s_ready) d_q <= s_data;
      end
    end
    assign m_valid = v_q;
    assign m_data  = d_q;
  end else begin : g_thru
    assign s_ready = m_ready;
    assign m_valid = s_valid;
    assign m_data  = s_data;
  end
endmodule

// File: rtl/grev_unit.sv
module grev_unit #(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] in_data,
  input  logic [XLEN-1:0] in_ctrl,
  input  logic            in_imm,
  input  logic            in_word,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_data,
  output logic            out_illegal,
  output logic            out_bswap
);
  localparam int NST = $clog2(XLEN);
  localparam int PW  = XLEN + 2;

  logic [XLEN-1:0] res_full, res_sel, res_c;
  logic            illegal_c, bswap_c;
  logic [PW-1:0]   pay_in, pay_out;

  grev_net #(.W(XLEN)) u_full (
    .d_i(in_data),
    .c_i(in_ctrl[NST-1:0]),
    .r_o(res_full)
  );

  if (XLEN == 64) begin : g_word
    logic [31:0] res_w;
    grev_net #(.W(32)) u_word (
      .d_i(in_data[31:0]),
      .c_i(in_ctrl[4:0]),
      .r_o(res_w)
    );
    assign res_sel = in_word ? {{32{res_w[31]}}, res_w} : res_full;
  end else begin : g_noword
    assign res_sel = res_full;
  end

  grev_ctrl_chk #(.XLEN(XLEN)) u_chk (
    .ctrl_i   (in_ctrl),
    .imm_i    (in_imm),
    .word_i   (in_word),
    .illegal_o(illegal_c),
    .bswap_o  (bswap_c)
  );

  assign res_c  = illegal_c ? '0 : res_sel;
  assign pay_in = {illegal_c, bswap_c, res_c};

  grev_pipe #(.PW(PW), .REG(OUT_REG)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data (pay_in),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (pay_out)
  );

  assign out_illegal = pay_out[PW-1];
  assign out_bswap   = pay_out[PW-2];
  assign out_data    = pay_out[XLEN-1:0];
endmodule

// File: rtl/grev_sva.sv
module grev_sva #(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1,
  localparam int NST = $clog2(XLEN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [XLEN-1:0] in_data,
  input logic [XLEN-1:0] in_ctrl,
  input logic            in_imm,
  input logic            in_word,
  input logic [XLEN-1:0] res_c,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_data,
  input logic            out_illegal,
  input logic            out_bswap
);
  assert_illegal_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_data == '0);

  assert_bswap_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bswap |-> !out_illegal);

  assert_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_imm && !in_word && in_ctrl[NST-1:0] == '0 |-> res_c == in_data);

  if (XLEN == 64) begin : g_w
    assert_signext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_word |-> res_c[63:32] == {32{res_c[31]}});
  end

  if (OUT_REG) begin : g_r
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)
        && $stable(out_illegal) && $stable(out_bswap));
    assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);
  end
endmodule

bind grev_unit grev_sva #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_sva (.*);

// File: tb/tb_grev_unit.sv
module tb_grev_unit;
  localparam int XL = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_imm = 1'b0, in_word = 1'b0, out_ready = 1'b0;
  logic [XL-1:0] in_data = '0, in_ctrl = '0;
  logic          in_ready, out_valid, out_illegal, out_bswap;
  logic [XL-1:0] out_data;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  grev_unit #(.XLEN(XL), .OUT_REG(1'b1)) dut (.*);

  function automatic logic [63:0] ref_perm(logic [63:0] d, logic [63:0] c, logic w);
    logic [63:0] r;
    if (w) begin
      for (int i = 0; i < 32; i++) r[i] = d[i ^ int'(c[4:0])];
      for (int i = 32; i < 64; i++) r[i] = r[31];
    end else begin
      for (int i = 0; i < 64; i++) r[i] = d[i ^ int'(c[5:0])];
    end
    return r;
  endfunction

  function automatic logic ref_ill(logic [63:0] c, logic w, logic im);
    return im && (c >= (w ? 64'd32 : 64'd64));
  endfunction

  function automatic logic ref_bsw(logic [63:0] c, logic w, logic im);
    if (ref_ill(c, w, im)) return 1'b0;
    return w ? (c[4:0] == 5'h18) : (c[5:0] == 6'h38);
  endfunction

  function automatic logic [63:0] byte_rev(logic [63:0] d, logic w);
    logic [63:0] r;
    if (w) begin
      for (int b = 0; b < 4; b++) r[8*b +: 8] = d[8*(3-b) +: 8];
      for (int i = 32; i < 64; i++) r[i] = r[31];
    end else begin
      for (int b = 0; b < 8; b++) r[8*b +: 8] = d[8*(7-b) +: 8];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One transfer with a stall of 'hold' cycles; returns the captured outputs.
  task automatic xfer(string req, logic [63:0] d, logic [63:0] c, logic w, logic im,
                      int hold, output logic [63:0] got, output logic ill,
                      output logic bsw);
    logic [63:0] first;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_ctrl = c; in_word = w; in_imm = im;
    chk("R7 in_ready empty", {63'd0, in_ready}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 latency", {63'd0, out_valid}, 64'd1);
    first = out_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R7 hold", {63'd0, out_valid}, 64'd1);
      chk("R7 stable", out_data, first);
    end
    got = out_data; ill = out_illegal; bsw = out_bswap;
    chk({req, " data"}, got, ref_ill(c, w, im) ? 64'd0 : ref_perm(d, c, w));
    chk("R3 illegal", {63'd0, ill}, {63'd0, ref_ill(c, w, im)});
    chk("R4 bswap", {63'd0, bsw}, {63'd0, ref_bsw(c, w, im)});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R7 drained", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] g, g2, d, c;
    logic il, bs, w, im;
    void'($urandom(32'h5eed_0042));
    // R8: input offered during reset must not be captured
    in_valid = 1'b1; in_data = 64'hdead; in_ctrl = 64'd1;
    repeat (3) @(negedge clk);
    chk("R8 reset out_valid", {63'd0, out_valid}, 64'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 after reset", {63'd0, out_valid}, 64'd0);

    d = 64'h0123_4567_89ab_cdef;
    xfer("R5 zero ctrl", d, 64'd0, 1'b0, 1'b0, 0, g, il, bs);
    chk("R5 identity", g, d);
    xfer("R1 full reverse", d, 64'd63, 1'b0, 1'b0, 1, g, il, bs);
    xfer("R1 upper ctrl ignored", d, 64'hffff_ff00_0000_0005, 1'b0, 1'b0, 0, g, il, bs);
    chk("R1 upper ctrl ignored eq", g, ref_perm(d, 64'd5, 1'b0));
    xfer("R4 rev8", d, 64'h38, 1'b0, 1'b0, 2, g, il, bs);
    chk("R4 byte swap", g, byte_rev(d, 1'b0));
    chk("R4 flag", {63'd0, bs}, 64'd1);
    xfer("R4 word rev8", d, 64'h18, 1'b1, 1'b0, 0, g, il, bs);
    chk("R4 word byte swap", g, byte_rev(d, 1'b1));
    xfer("R2 word ctrl hi ignored", 64'hffff_0000_8000_0001, 64'hffe5, 1'b1, 1'b0, 0, g, il, bs);
    xfer("R2 word ctrl ref", 64'h0000_0000_8000_0001, 64'h05, 1'b1, 1'b0, 0, g2, il, bs);
    chk("R2 high operand ignored", g, g2);
    xfer("R1 imm 63 legal", d, 64'd63, 1'b0, 1'b1, 0, g, il, bs);
    xfer("R3 imm 64 illegal", d, 64'd64, 1'b0, 1'b1, 1, g, il, bs);
    chk("R3 flag 64", {63'd0, il}, 64'd1);
    xfer("R3 word imm 32", d, 64'd32, 1'b1, 1'b1, 0, g, il, bs);
    chk("R3 flag word 32", {63'd0, il}, 64'd1);
    xfer("R2 word imm 31", d, 64'd31, 1'b1, 1'b1, 0, g, il, bs);
    chk("R3 word 31 legal", {63'd0, il}, 64'd0);

    for (int n = 0; n < 300; n++) begin
      d = {$urandom, $urandom};
      w = 1'($urandom);
      im = 1'($urandom);
      c = im ? 64'($urandom % 80) : {$urandom, $urandom};
      xfer(w ? "R2 random" : "R1 random", d, c, w, im, int'($urandom % 4), g, il, bs);
      if (!il) begin
        xfer("R6 second pass", g, c, w, 1'b0, 0, g2, il, bs);
        chk("R6 involution", g2, w ? {{32{d[31]}}, d[31:0]} : d);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule